// File: doc/BRIEF.md
# 64-bit Counter-Based Mixing Random Generator

This block produces a stream of 64-bit pseudo-random words. It keeps a 64-bit counter state. Each accepted request adds a fixed odd increment, the golden-ratio constant 0x9e3779b97f4a7c15, to that state. The block then sends the incremented value through three mixing rounds built from xor-shifts and multiplies. The caller only sees the mixed word and never the counter. Mixing reads the state but never writes it.

A client pulses `req` for each word it wants. It can accept on every cycle. Results come back on `rnd_data`, qualified by `rnd_valid`, with a fixed latency and in request order. A one-cycle `seed_load` strobe writes a new 64-bit state at any time. It also throws away every result that has not yet appeared, so no word from the old seed is delivered after the strobe.

Top module: `mix64_rng`

## Requirements
- R1: While reset is held and in the first cycle after it, `rnd_valid` is 0, `rnd_data` is 0 and the state equals the parameter `RESET_SEED` (default 0).
- R2: When `seed_load` is 1 at a clock edge, the state takes `seed_value` at that edge. A `req` sampled at the same edge is dropped: it does not advance the state and it produces no output.
- R3: Each request accepted at an edge (`req`=1, `seed_load`=0) adds 0x9e3779b97f4a7c15 to the state, modulo 2^64. With no request and no load, the state holds.
- R4: The word for an accepted request is computed from the incremented state z in three steps. First z = (z ^ (z >> 30)) * 0xbf58476d1ce4e5b9. Then z = (z ^ (z >> 27)) * 0x94d049bb133111eb. The result is z ^ (z >> 31). Shifts are logical and each product keeps only its low 64 bits. From state 0 the first word is 0xe220a8397b1dcdaf.
- R5: A request accepted at clock edge k sets `rnd_valid` to 1 with its word on `rnd_data` after edge k+3, for exactly one cycle.
- R6: Requests accepted on consecutive edges produce one word each, on consecutive cycles, in request order.
- R7: A `seed_load` at edge k discards the results of the requests accepted at edges k-3 to k-1. None of them ever raises `rnd_valid`.
- R8: While `rnd_valid` is 0, `rnd_data` keeps the last word delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| seed_load | input | 1 | Write `seed_value` into the state and flush words in flight |
| seed_value | input | 64 | New state value |
| req | input | 1 | Request one word |
| rnd_valid | output | 1 | `rnd_data` holds a new word this cycle |
| rnd_data | output | 64 | Mixed random word |

## Verification
The assertions rely on two things about the inputs. First, `req` and `seed_load` are low while reset is held. Second, both are known (0 or 1) at every sampled edge, because the latency and flush properties look back through their values. The bench meets both: it holds every input at 0 through reset and drives them only at falling edges, always to defined values. It mixes about 1500 cycles of random requests and occasional random seeds with directed cases. The directed cases cover a request at the same edge as a load, loads in the middle of back-to-back bursts, and idle gaps.

// File: rtl/mix64_pkg.sv
package mix64_pkg;

    localparam int unsigned MIX_W      = 64;
    localparam int unsigned MIX_ROUNDS = 3;

    localparam logic [MIX_W-1:0] MIX_STEP = 64'h9e3779b97f4a7c15;
    localparam logic [MIX_W-1:0] MIX_K1   = 64'hbf58476d1ce4e5b9;
    localparam logic [MIX_W-1:0] MIX_K2   = 64'h94d049bb133111eb;

    typedef struct packed {
        logic             vld;
        logic [MIX_W-1:0] data;
    } mix_slot_t;

    // Right-shift distance of each round.
    function automatic int unsigned round_shift(input int unsigned idx);
        case (idx)
            0:       return 30;
            1:       return 27;
            default: return 31;
        endcase
    endfunction

    // Whether a round ends with a multiply.
    function automatic bit round_has_mul(input int unsigned idx);
        return idx < 2;
    endfunction

    function automatic logic [MIX_W-1:0] round_mul(input int unsigned idx);
        return (idx == 0) ? MIX_K1 : MIX_K2;
    endfunction

endpackage

// File: rtl/mix64_state.sv
module mix64_state
    import mix64_pkg::*;
#(
    parameter logic [MIX_W-1:0] RESET_SEED = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             seed_load,
    input  logic [MIX_W-1:0] seed_value,
    input  logic             req,
    output logic [MIX_W-1:0] state_o,
    output mix_slot_t        issue_o
);

    typedef struct packed {
        logic [MIX_W-1:0] state;
        mix_slot_t        issue;
    } state_regs_t;

    state_regs_t regs_d, regs_q;

    always_comb begin
        regs_d           = regs_q;
        regs_d.issue.vld = 1'b0;
        if (seed_load) begin
            regs_d.state = seed_value;
        end else if (req) begin
            regs_d.state      = regs_q.state + MIX_STEP;
            regs_d.issue.vld  = 1'b1;
            regs_d.issue.data = regs_q.state + MIX_STEP;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q.state <= RESET_SEED;
            regs_q.issue <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign state_o = regs_q.state;
    assign issue_o = regs_q.issue;

endmodule

// File: rtl/mix64_round.sv
module mix64_round
    import mix64_pkg::*;
#(
    parameter int unsigned      SHIFT   = 30,
    parameter bit               HAS_MUL = 1'b1,
    parameter logic [MIX_W-1:0] MULT    = MIX_K1
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      flush,
    input  mix_slot_t in_slot,
    output mix_slot_t out_slot
);

    logic [MIX_W-1:0] folded;
    logic [MIX_W-1:0] mixed;
    mix_slot_t        slot_d, slot_q;

    assign folded = in_slot.data ^ (in_slot.data >> SHIFT);

    generate
        if (HAS_MUL) begin : g_mul
            assign mixed = folded * MULT;
        end else begin : g_pass
            assign mixed = folded;
        end
    endgenerate

    always_comb begin
        slot_d     = slot_q;
        slot_d.vld = 1'b0;
        if (!flush && in_slot.vld) begin
            slot_d.vld  = 1'b1;
            slot_d.data = mixed;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slot_q <= '0;
        end else begin
            slot_q <= slot_d;
        end
    end

    assign out_slot = slot_q;

endmodule

// File: rtl/mix64_rng.sv
module mix64_rng
    import mix64_pkg::*;
#(
    parameter logic [MIX_W-1:0] RESET_SEED = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             seed_load,
    input  logic [MIX_W-1:0] seed_value,
    input  logic             req,
    output logic             rnd_valid,
    output logic [MIX_W-1:0] rnd_data
);

    mix_slot_t        pipe [0:MIX_ROUNDS];
    logic [MIX_W-1:0] state_w;

    mix64_state #(
        .RESET_SEED (RESET_SEED)
    ) u_state (
        .clk        (clk),
        .rst_n      (rst_n),
        .seed_load  (seed_load),
        .seed_value (seed_value),
        .req        (req),
        .state_o    (state_w),
        .issue_o    (pipe[0])
    );

    generate
        for (genvar gi = 0; gi < MIX_ROUNDS; gi++) begin : g_round
            mix64_round #(
                .SHIFT   (round_shift(gi)),
                .HAS_MUL (round_has_mul(gi)),
                .MULT    (round_mul(gi))
            ) u_round (
                .clk      (clk),
                .rst_n    (rst_n),
                .flush    (seed_load),
                .in_slot  (pipe[gi]),
                .out_slot (pipe[gi+1])
            );
        end
    endgenerate

    assign rnd_valid = pipe[MIX_ROUNDS].vld;
    assign rnd_data  = pipe[MIX_ROUNDS].data;

endmodule

// File: rtl/mix64_rng_chk.sv
module mix64_rng_chk
    import mix64_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             seed_load,
    input logic [MIX_W-1:0] seed_value,
    input logic             req,
    input logic             rnd_valid,
    input logic [MIX_W-1:0] rnd_data,
    input logic [MIX_W-1:0] state
);

    logic [2:0] warm_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            warm_q <= '0;
        end else if (warm_q != 3'd7) begin
            warm_q <= warm_q + 3'd1;
        end
    end

    AST_OUT_KNOWN: assert property (@(posedge clk) disable iff (!rst_n)
        !$isunknown({rnd_valid, rnd_data}));  // R8

    AST_SEED_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q >= 3'd1 && $past(seed_load)) |-> state == $past(seed_value));  // R2

    AST_STATE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q >= 3'd1 && $past(req && !seed_load)) |-> state == $past(state) + MIX_STEP);  // R3

    AST_STATE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q >= 3'd1 && !$past(req) && !$past(seed_load)) |-> $stable(state));  // R3

    AST_VALID_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q >= 3'd4 && rnd_valid) |-> $past(req && !seed_load, 4));  // R5

    AST_FLUSH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q >= 3'd3 && ($past(seed_load, 1) || $past(seed_load, 2) || $past(seed_load, 3)))
        |-> !rnd_valid);  // R7

    AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q >= 3'd1 && !rnd_valid) |-> $stable(rnd_data));  // R8

endmodule

bind mix64_rng mix64_rng_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .seed_load  (seed_load),
    .seed_value (seed_value),
    .req        (req),
    .rnd_valid  (rnd_valid),
    .rnd_data   (rnd_data),
    .state      (state_w)
);

// File: tb/mix64_rng_tb.sv
module mix64_rng_tb;

    localparam time         CLK_PERIOD = 10ns;
    localparam logic [63:0] STEP = 64'h9e3779b97f4a7c15;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        seed_load;
    logic [63:0] seed_value;
    logic        req;
    logic        rnd_valid;
    logic [63:0] rnd_data;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // Expected-value model: counter state and the timing of each word (R5).
    logic [63:0] m_state;
    logic        m_v [0:3];
    logic [63:0] m_d [0:3];
    logic [63:0] m_out;

    always #(CLK_PERIOD / 2) clk = ~clk;

    mix64_rng u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .seed_load  (seed_load),
        .seed_value (seed_value),
        .req        (req),
        .rnd_valid  (rnd_valid),
        .rnd_data   (rnd_data)
    );

    function automatic logic [63:0] mix(input logic [63:0] z0);
        logic [63:0] z;
        z = z0;
        z = (z ^ (z >> 30)) * 64'hbf58476d1ce4e5b9;
        z = (z ^ (z >> 27)) * 64'h94d049bb133111eb;
        return z ^ (z >> 31);
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // Drive one cycle, advance the model at the edge, compare at the falling edge.
    task automatic cycle(input logic ld, input logic [63:0] sd, input logic rq, input string tag);
        seed_load  = ld;
        seed_value = sd;
        req        = rq;
        @(posedge clk);
        if (ld) begin
            m_state = sd;
            for (int i = 0; i < 4; i++) m_v[i] = 1'b0;
        end else begin
            for (int i = 3; i > 0; i--) begin
                m_v[i] = m_v[i-1];
                m_d[i] = m_d[i-1];
            end
            m_v[0] = rq;
            if (rq) begin
                m_state = m_state + STEP;
                m_d[0]  = mix(m_state);
            end
        end
        if (m_v[3]) m_out = m_d[3];
        @(negedge clk);
        chk({tag, " valid"}, {63'd0, rnd_valid}, {63'd0, m_v[3]});
        chk({tag, " data"}, rnd_data, m_out);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int unsigned junk;
        junk = $urandom(32'h5eed);
        rst_n = 1'b0; seed_load = 1'b0; seed_value = '0; req = 1'b0;
        m_state = '0; m_out = '0;
        for (int i = 0; i < 4; i++) begin m_v[i] = 1'b0; m_d[i] = '0; end
        repeat (3) @(negedge clk);
        // R1: outputs idle during reset
        chk("R1 reset valid", {63'd0, rnd_valid}, 64'd0);
        chk("R1 reset data", rnd_data, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after reset valid", {63'd0, rnd_valid}, 64'd0);

        // R4: known answer from the default state of zero
        cycle(1'b0, '0, 1'b1, "R4 kat");
        repeat (3) cycle(1'b0, '0, 1'b0, "R5 latency");
        chk("R4 known answer", rnd_data, 64'he220a8397b1dcdaf);

        // R8: idle cycles keep the last word
        repeat (4) cycle(1'b0, '0, 1'b0, "R8 idle hold");

        // R6: back-to-back burst, then R3 stepping via output words
        repeat (8) cycle(1'b0, '0, 1'b1, "R6 burst");
        repeat (4) cycle(1'b0, '0, 1'b0, "R6 drain");

        // R2: load and request on the same edge; request dropped
        cycle(1'b1, 64'h0123456789abcdef, 1'b1, "R2 load+req");
        repeat (5) cycle(1'b0, '0, 1'b0, "R2 no output");
        cycle(1'b0, '0, 1'b1, "R2 first after seed");
        repeat (3) cycle(1'b0, '0, 1'b0, "R3 step from seed");

        // R7: load in the middle of a burst discards in-flight words
        repeat (3) cycle(1'b0, '0, 1'b1, "R7 burst");
        cycle(1'b1, 64'hffffffffffffffff, 1'b0, "R7 flush");
        repeat (3) cycle(1'b0, '0, 1'b0, "R7 quiet");
        repeat (2) cycle(1'b0, '0, 1'b1, "R3 wrap");
        repeat (4) cycle(1'b0, '0, 1'b0, "R3 wrap drain");

        // Random mix of requests and occasional reseeds
        for (int n = 0; n < 1500; n++) begin
            logic ld;
            ld = ($urandom_range(0, 99) < 2);
            cycle(ld, {$urandom, $urandom}, ($urandom_range(0, 99) < 65), "R4 R5 R6 R7 random");
        end
        repeat (4) cycle(1'b0, '0, 1'b0, "R5 final drain");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule